// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Sequence

This peripheral guards a system against software that stops running. Software programs an 8-bit timeout field and sets an enable bit in a 16-bit control register. From then on a counter steps down on every half-second tick pulse. If it runs out, the block raises a single-cycle reset request for the system reset controller. To hold off the request, software writes two fixed key words, in order, to a separate service register. A valid pair reloads the counter from the timeout field.

The enable bit is write-once: only a reset clears it. The timeout field counts in half-second steps, so a field value N gives (N+1) half-second ticks before expiry. Software therefore programs 2×seconds−1. After reset the field holds 0x13, which is ten seconds. The field stays writable while the timer runs. A new value is used only at the next reload.

Three state machines do the work:
- The key checker has states KEY_IDLE and KEY_ARMED. A first key moves it from KEY_IDLE to KEY_ARMED. A second key moves it from KEY_ARMED back to KEY_IDLE with a reload. Any other service value moves it to KEY_IDLE with no reload.
- The counter has states CNT_OFF, CNT_RUN and CNT_HALT. A load moves it from CNT_OFF or CNT_HALT to CNT_RUN. A tick at zero moves it from CNT_RUN to CNT_HALT and fires the request.
- The control register holds the enable and field state: it starts disabled, and setting the enable bit starts the counter.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, a read of the control register at address 0 returns 0x1300: field 0x13 in bits [15:8] and enable bit 0 clear. The `expire` output is low.
- R2: The control register at address 0 keeps the timeout field in bits [15:8] and the enable in bit 0. All other bits read 0. Reads of addresses 1, 2 and 3 return 0, and writes to addresses 2 and 3 change nothing.
- R3: Once the enable bit is 1, writing 0 to bit 0 leaves it 1 until reset.
- R4: A control write that sets bit 0 while the timer is disabled loads the counter with the field value N from that same write. `expire` then goes high in the cycle after the (N+1)-th tick that follows.
- R5: While the timer is disabled, ticks never cause `expire`.
- R6: A service write (address 1) of 0x5555, followed by a service write of 0xAAAA as the next service write, reloads the counter from the current field. This reload happens only while the timer is enabled.
- R7: Any service value other than 0xAAAA written after 0x5555 aborts the sequence, and this includes a second 0x5555. An 0xAAAA without a preceding 0x5555 does nothing. Writes to other addresses between the two keys do not break the sequence.
- R8: A field change while the timer is enabled does not alter the running count. It takes effect at the next reload.
- R9: Expiry gives a one-cycle `expire` pulse, and counting then stops with no further pulse. A later valid reload restarts counting.
- R10: When a reload and a tick fall in the same cycle, the reload wins: the counter takes the field value and no pulse follows from that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one 16-bit write per cycle |
| addr | input | 2 | Word address: 0 control, 1 service |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| tick | input | 1 | Half-second tick-enable pulse |
| expire | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions take for granted that `tick` is a single-cycle enable synchronous to `clk`. They also assume that at most one register write arrives per cycle, so a control write and a service write never coincide. The stimulus drives every input one step after the falling edge and issues one write per step at a single address. It draws ticks on roughly a third of the cycles, so ticks often coincide with key writes and reloads. Small random field values keep expiry frequent enough that halts and restarts are exercised many times.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {CNT_OFF, CNT_RUN, CNT_HALT} cnt_state_t;
    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_t;
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg #(
    parameter int          DATA_W    = 16,
    parameter int          FIELD_W   = 8,
    parameter logic [7:0]  RST_FIELD = 8'h13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic [DATA_W-1:0]  wdata,
    output logic               enable,
    output logic               start,
    output logic [FIELD_W-1:0] load_field,
    output logic [DATA_W-1:0]  rd_ctrl
);
    localparam int FIELD_LSB = DATA_W - FIELD_W;

    logic               en_q;
    logic [FIELD_W-1:0] field_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            field_q <= FIELD_W'(RST_FIELD);
        end else if (wr_ctrl) begin
            en_q    <= en_q | wdata[0];
            field_q <= wdata[DATA_W-1:FIELD_LSB];
        end
    end

    always_comb begin
        start      = wr_ctrl && wdata[0] && !en_q;
        load_field = wr_ctrl ? wdata[DATA_W-1:FIELD_LSB] : field_q;
        rd_ctrl    = '0;
        rd_ctrl[DATA_W-1:FIELD_LSB] = field_q;
        rd_ctrl[0] = en_q;
        enable     = en_q;
    end

    // R3: enable is sticky once set
    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
    import wdg_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY_A  = 16'h5555,
    parameter logic [DATA_W-1:0] KEY_B  = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_svc,
    input  logic [DATA_W-1:0] wdata,
    output logic              reload
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        reload  = 1'b0;
        if (wr_svc) begin
            unique case (state_q)
                KEY_IDLE:  state_d = (wdata == KEY_A) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: begin
                    state_d = KEY_IDLE;
                    reload  = (wdata == KEY_B);
                end
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    // R7: a key pair leaves the checker idle, never armed
    a_r7_pair_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> state_q == KEY_IDLE);
    // R6: a service write while armed always disarms
    a_r6_armed_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_svc && state_q == KEY_ARMED) |=> state_q == KEY_IDLE);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    input  logic               tick,
    output logic               expire
);
    cnt_state_t         state_q, state_d;
    logic [FIELD_W-1:0] cnt_q, cnt_d;
    logic               exp_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_OFF;
            cnt_q   <= '0;
            expire  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            expire  <= exp_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        exp_d   = 1'b0;
        if (load) begin
            state_d = CNT_RUN;
            cnt_d   = load_val;
        end else begin
            unique case (state_q)
                CNT_OFF:  ;
                CNT_RUN:  if (tick) begin
                    if (cnt_q == '0) begin
                        state_d = CNT_HALT;
                        exp_d   = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                CNT_HALT: ;
                default:  state_d = CNT_OFF;
            endcase
        end
    end

    // R5: no counting while disabled
    a_r5_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (state_q == CNT_OFF && !expire));
    // R9: a single pulse, then halted
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (!$past(expire) && state_q == CNT_HALT));
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HALT && !load) |=> (state_q == CNT_HALT && !expire));
    // R10: load has priority over a tick
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tick) |=> (!expire && cnt_q == $past(load_val)));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
    parameter int                DATA_W    = 16,
    parameter int                FIELD_W   = 8,
    parameter int                ADDR_W    = 2,
    parameter logic [7:0]        RST_FIELD = 8'h13,
    parameter logic [DATA_W-1:0] KEY_A     = 16'h5555,
    parameter logic [DATA_W-1:0] KEY_B     = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              expire
);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_SVC  = ADDR_W'(1);

    logic               wr_ctrl, wr_svc, enable, start, reload, load;
    logic [FIELD_W-1:0] load_field;
    logic [DATA_W-1:0]  rd_ctrl;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_svc  = wr_en && (addr == ADDR_SVC);
    assign load    = start || (reload && enable);
    assign rd_data = (addr == ADDR_CTRL) ? rd_ctrl : '0;

    wdg_ctrl_reg #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .RST_FIELD(RST_FIELD)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wr_data),
        .enable(enable), .start(start), .load_field(load_field), .rd_ctrl(rd_ctrl)
    );

    wdg_key_seq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) key_i (
        .clk(clk), .rst_n(rst_n), .wr_svc(wr_svc), .wdata(wr_data), .reload(reload)
    );

    wdg_countdown #(.FIELD_W(FIELD_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .load(load),
        .load_val(load_field), .tick(tick), .expire(expire)
    );

    // R4: starting the timer never coincides with a pulse on the next cycle
    a_r4_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !expire);
endmodule

// File: tb/svc_watchdog_tb_top.sv
module svc_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        tick = 1'b0;
    logic        expire;

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag = "R1";

    // reference model state
    logic       m_en;
    logic [7:0] m_to;
    logic       m_key;
    logic [7:0] m_cnt;
    int         m_st;   // 0 off, 1 run, 2 halt
    logic       m_exp;

    always #4 clk = ~clk;

    svc_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .expire(expire)
    );

    function automatic logic [15:0] ctrl_view(logic [7:0] f, logic e);
        return {f, 7'b0, e};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_to = 8'h13; m_key = 0; m_cnt = 0; m_st = 0; m_exp = 0;
    endtask

    task automatic step(bit w, logic [1:0] a, logic [15:0] d, bit t);
        logic wc, ws, st, rl;
        logic [7:0] lv;
        wr_en = w; addr = a; wr_data = d; tick = t;
        #1;
        chk({tag, " read"}, rd_data, (a == 2'd0) ? ctrl_view(m_to, m_en) : 16'h0);
        wc = w && a == 2'd0;
        ws = w && a == 2'd1;
        st = wc && d[0] && !m_en;
        rl = ws && m_key && d == 16'hAAAA;
        lv = wc ? d[15:8] : m_to;
        if (ws) m_key = m_key ? 1'b0 : (d == 16'h5555);
        if (wc) m_to = d[15:8];
        m_exp = 0;
        if (st || (rl && m_en)) begin
            m_cnt = lv; m_st = 1;
        end else if (m_st == 1 && t) begin
            if (m_cnt == 0) begin m_exp = 1; m_st = 2; end
            else m_cnt = m_cnt - 1;
        end
        if (wc && d[0]) m_en = 1;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " expire"}, {15'b0, expire}, {15'b0, m_exp});
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 16'h0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int pulses;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        tag = "R1";
        chk("R1 reset ctrl", rd_data, 16'h1300);
        chk("R1 reset expire", {15'b0, expire}, 16'h0);

        tag = "R2";
        step(1, 2'd0, 16'h03FE, 0);
        chk("R2 field only", rd_data, 16'h0300);
        step(1, 2'd2, 16'hFFFF, 0);
        step(0, 2'd3, 16'h0, 0);
        step(0, 2'd1, 16'h0, 0);

        tag = "R5";
        step(1, 2'd1, 16'h5555, 1);
        step(1, 2'd1, 16'hAAAA, 1);
        ticks(8);

        tag = "R4";
        step(1, 2'd0, 16'h0301, 0);
        pulses = 0;
        for (int i = 0; i < 4; i++) begin
            step(0, 2'd0, 16'h0, 1);
            if (expire) pulses++;
        end
        chk("R4 pulse after 4th tick", 16'(pulses), 16'd1);

        tag = "R9";
        ticks(6);
        tag = "R3";
        step(1, 2'd0, 16'h0200, 0);
        chk("R3 enable kept", rd_data, 16'h0201);

        tag = "R6";
        step(1, 2'd1, 16'h5555, 0);
        step(1, 2'd1, 16'hAAAA, 0);
        ticks(4);

        tag = "R8";
        step(1, 2'd1, 16'h5555, 0);
        step(1, 2'd1, 16'hAAAA, 0);
        step(1, 2'd0, 16'h0600, 1);
        ticks(3);

        tag = "R7";
        step(1, 2'd1, 16'h5555, 0);
        step(1, 2'd2, 16'h1234, 0);
        step(1, 2'd0, 16'h0100, 0);
        step(1, 2'd1, 16'hAAAA, 0);
        step(1, 2'd1, 16'h5555, 0);
        step(1, 2'd1, 16'h5555, 0);
        step(1, 2'd1, 16'hAAAA, 1);
        step(1, 2'd1, 16'hAAAA, 1);
        ticks(3);

        tag = "R10";
        step(1, 2'd1, 16'h5555, 0);
        step(1, 2'd1, 16'hAAAA, 1);
        ticks(3);

        tag = "R6 R7 R8 R9 R10";
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit t;
            r = int'($urandom % 16);
            t = ($urandom % 3) == 0;
            if (r < 4)       step(1, 2'd1, 16'h5555, t);
            else if (r < 7)  step(1, 2'd1, 16'hAAAA, t);
            else if (r == 7) step(1, 2'd1, 16'($urandom), t);
            else if (r == 8) step(1, 2'd0, {5'b0, 3'($urandom), 7'($urandom), 1'($urandom)}, t);
            else if (r == 9) step(1, 2'(2 + $urandom % 2), 16'($urandom), t);
            else             step(0, 2'($urandom), 16'h0, t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule